// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sleep and Wakeup

This block turns a serial input line into 8-bit or 9-bit characters. The line is sampled on a 16x oversampling enable. A falling edge is only taken as a start bit if the line is still low at the middle of that bit. Data bits arrive least significant first and are sampled at mid-bit. When a character completes, the receiver gives a one-cycle data-ready strobe, with a framing-error flag if the stop bit was low. In 9-bit mode the extra bit is passed through unchanged as bit 8 of the received word.

Alongside framing, an idle detector counts consecutive high oversample ticks. When the count reaches one full character time, it emits a single idle pulse. A control input chooses where the count may start. It can start from the first data bit, so a run of ones at the end of a character counts toward idle. It can instead start only after the stop bit has been sampled. After an idle pulse, the detector stays silent until a new start bit is confirmed.

A sleep strobe puts the receiver to sleep. While asleep it delivers no characters and flags no errors. A wake-select input chooses how it wakes. In address-mark mode, a character whose top bit is 1 wakes it, and that character is delivered. In idle-line mode, an idle pulse wakes it, and the next character is delivered.

Top module: `uart_rx_wake`

## Requirements
- R1: In 8-bit mode (char9=0) a frame is one low start bit, 8 data bits least significant first, then a stop bit. The data appear on rx_data[7:0] with rx_data[8]=0, and rx_valid pulses high for exactly one cycle.
- R2: With char9=1 a ninth data bit follows the eighth and appears on rx_data[8].
- R3: A low level that no longer holds at the mid-bit sample (8 ticks after the falling edge) is dropped without a character.
- R4: A low stop bit sets frame_err during the same cycle as rx_valid. frame_err is never high without rx_valid.
- R5: An idle condition is one character time of consecutive high ticks: 10 bit times (160 ticks) with char9=0, and 11 bit times (176 ticks) with char9=1. It is reported as a one-cycle idle_pulse.
- R6: After an idle pulse, including the one that follows reset on an idle line, no further idle pulse occurs until a start bit has been confirmed.
- R7: With idle_after_stop=0, high ticks count from the first data bit onward. A character of all ones followed by about one bit time of idle line therefore yields an idle pulse.
- R8: With idle_after_stop=1, counting begins only after the stop bit has been sampled. A gap of 3 bit times after a character gives no idle pulse.
- R9: A one-cycle sleep_req sets asleep on the next clock edge. While asleep, rx_valid and frame_err stay low, except for the waking character of R10.
- R10: With wake_addr=1, a sleeping receiver ignores characters whose mark bit is 0. The mark bit is rx bit 7 with char9=0 and rx bit 8 with char9=1. A character with mark bit 1 clears asleep and is delivered with rx_valid.
- R11: With wake_addr=0, a sleeping receiver ignores characters. An idle pulse clears asleep in the same cycle without delivering a character, and the following character is delivered.
- R12: After reset, rx_valid, frame_err, idle_pulse and asleep are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | Serial input line, idle high |
| char9 | input | 1 | 1 selects 9-bit characters, 0 selects 8-bit |
| wake_addr | input | 1 | 1 selects address-mark wakeup, 0 selects idle-line wakeup |
| idle_after_stop | input | 1 | 1 starts the idle count after the stop bit, 0 after the start bit |
| sleep_req | input | 1 | One-cycle strobe that puts the receiver to sleep |
| rx_data | output | 9 | Received character; bit 8 is the ninth bit |
| rx_valid | output | 1 | One-cycle data-ready strobe |
| idle_pulse | output | 1 | One-cycle idle-line indication |
| frame_err | output | 1 | Stop bit was low; valid with rx_valid |
| asleep | output | 1 | Receiver sleep status |

## Verification
The bound checker watches several rules on every cycle. It checks that the strobes last one cycle and that a framing error never appears without data-ready. It checks that sleep is entered only on request and that a sleeping receiver in idle-line mode stays silent. It also checks that each wake-up coincides with its cause: an idle pulse in one mode, a delivered character in the other. Only the directed scenarios can show what depends on line timing. These are the exact received values, the rejection of short start glitches, the 10- versus 11-bit idle thresholds, and the different counting start points. They also cover the once-per-start limit on idle pulses and the choice of which character wakes and is delivered.

// File: rtl/uart_rx_wake_pkg.sv
package uart_rx_wake_pkg;

  typedef enum logic [1:0] {
    FR_HUNT  = 2'd0,
    FR_START = 2'd1,
    FR_DATA  = 2'd2,
    FR_STOP  = 2'd3
  } frame_st_e;

  // ticks of high line that make up one idle character (start + data + stop)
  function automatic int unsigned idle_ticks(input int unsigned dbits,
                                             input int unsigned osr,
                                             input bit          nine);
    return (dbits + (nine ? 3 : 2)) * osr;
  endfunction

endpackage

// File: rtl/rxw_sync.sv
module rxw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxw_framer.sv
module rxw_framer
  import uart_rx_wake_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           line,
  input  logic           char9,
  output logic           hunt,
  output logic           start_ok,
  output logic           done,
  output logic           stop_bad,
  output logic           mark,
  output logic [DBITS:0] data
);
  localparam int DW   = DBITS + 1;
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int BW   = $clog2(DBITS + 2);

  frame_st_e      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  bidx;
  logic [BW-1:0]  last_idx;
  logic           len9;
  logic [DW-1:0]  shreg;

  assign last_idx = len9 ? BW'(DBITS) : BW'(DBITS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FR_HUNT;
      cnt      <= '0;
      bidx     <= '0;
      len9     <= 1'b0;
      shreg    <= '0;
      start_ok <= 1'b0;
      done     <= 1'b0;
      stop_bad <= 1'b0;
    end else begin
      start_ok <= 1'b0;
      done     <= 1'b0;
      if (tick) begin
        unique case (st)
          FR_HUNT: begin
            if (!line) begin
              st  <= FR_START;
              cnt <= '0;
            end
          end
          FR_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (!line) begin
                st       <= FR_DATA;
                bidx     <= '0;
                len9     <= char9;
                start_ok <= 1'b1;
              end else begin
                st <= FR_HUNT;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_DATA: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt   <= '0;
              shreg <= {line, shreg[DW-1:1]};
              bidx  <= bidx + 1'b1;
              if (bidx == last_idx) st <= FR_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          FR_STOP: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt      <= '0;
              st       <= FR_HUNT;
              done     <= 1'b1;
              stop_bad <= !line;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= FR_HUNT;
        endcase
      end
    end
  end

  // last received bit always lands in the top position of the shifter
  assign mark = shreg[DW-1];
  assign data = len9 ? shreg : {1'b0, shreg[DW-1:1]};
  assign hunt = (st == FR_HUNT);
endmodule

// File: rtl/rxw_idle.sv
module rxw_idle
  import uart_rx_wake_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DBITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic hunt,
  input  logic start_ok,
  input  logic char9,
  input  logic after_stop,
  output logic hit
);
  localparam int unsigned MAXT = idle_ticks(DBITS, OSR, 1'b1);
  localparam int unsigned MINT = idle_ticks(DBITS, OSR, 1'b0);
  localparam int IW = $clog2(MAXT + 1);

  logic [IW-1:0] cnt;
  logic [IW-1:0] lim;
  logic          fired;
  logic          hold;

  assign lim  = char9 ? IW'(MAXT - 1) : IW'(MINT - 1);
  assign hold = !line || (after_stop && !hunt);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
      hit   <= 1'b0;
    end else begin
      hit <= 1'b0;
      if (start_ok) fired <= 1'b0;
      if (tick) begin
        if (hold) begin
          cnt <= '0;
        end else if (!fired) begin
          if (cnt >= lim) begin
            cnt   <= '0;
            hit   <= 1'b1;
            fired <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rxw_wake.sv
module rxw_wake #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic          stop_bad,
  input  logic          mark,
  input  logic [DW-1:0] data,
  input  logic          idle_hit,
  input  logic          wake_addr,
  input  logic          sleep_req,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          frame_err,
  output logic          idle_pulse,
  output logic          asleep
);
  logic mark_wake;
  logic idle_wake;
  logic deliver;

  assign mark_wake = asleep && wake_addr && done && mark;
  assign idle_wake = asleep && !wake_addr && idle_hit;
  assign deliver   = done && (!asleep || mark_wake);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      idle_pulse <= 1'b0;
      asleep     <= 1'b0;
    end else begin
      rx_valid   <= deliver;
      frame_err  <= deliver && stop_bad;
      idle_pulse <= idle_hit;
      if (deliver) rx_data <= data;
      if (sleep_req)                   asleep <= 1'b1;
      else if (mark_wake || idle_wake) asleep <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake #(
  parameter int OSR         = 16,
  parameter int DBITS       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           os_tick,
  input  logic           rxd,
  input  logic           char9,
  input  logic           wake_addr,
  input  logic           idle_after_stop,
  input  logic           sleep_req,
  output logic [DBITS:0] rx_data,
  output logic           rx_valid,
  output logic           idle_pulse,
  output logic           frame_err,
  output logic           asleep
);
  localparam int DW = DBITS + 1;

  logic          line;
  logic          hunt;
  logic          start_ok;
  logic          done;
  logic          stop_bad;
  logic          mark;
  logic [DW-1:0] fdata;
  logic          idle_hit;

  rxw_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rxd),
    .dout (line)
  );

  rxw_framer #(.OSR(OSR), .DBITS(DBITS)) i_framer (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .line     (line),
    .char9    (char9),
    .hunt     (hunt),
    .start_ok (start_ok),
    .done     (done),
    .stop_bad (stop_bad),
    .mark     (mark),
    .data     (fdata)
  );

  rxw_idle #(.OSR(OSR), .DBITS(DBITS)) i_idle (
    .clk        (clk),
    .rst        (rst),
    .tick       (os_tick),
    .line       (line),
    .hunt       (hunt),
    .start_ok   (start_ok),
    .char9      (char9),
    .after_stop (idle_after_stop),
    .hit        (idle_hit)
  );

  rxw_wake #(.DW(DW)) i_wake (
    .clk        (clk),
    .rst        (rst),
    .done       (done),
    .stop_bad   (stop_bad),
    .mark       (mark),
    .data       (fdata),
    .idle_hit   (idle_hit),
    .wake_addr  (wake_addr),
    .sleep_req  (sleep_req),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .frame_err  (frame_err),
    .idle_pulse (idle_pulse),
    .asleep     (asleep)
  );
endmodule

// File: rtl/uart_rx_wake_chk.sv
module uart_rx_wake_chk (
  input logic clk,
  input logic rst,
  input logic wake_addr,
  input logic sleep_req,
  input logic rx_valid,
  input logic idle_pulse,
  input logic frame_err,
  input logic asleep
);
  // R1
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R5
  idle_single_chk: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |=> !idle_pulse);

  // R4
  ferr_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> rx_valid);

  // R9
  sleep_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(asleep) |-> $past(sleep_req));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (asleep && !wake_addr) |=> !rx_valid);

  // R11
  wake_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(asleep) && !$past(wake_addr)) |-> (idle_pulse && !rx_valid));

  // R10
  wake_mark_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(asleep) && $past(wake_addr)) |-> rx_valid);
endmodule

bind uart_rx_wake uart_rx_wake_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .wake_addr  (wake_addr),
  .sleep_req  (sleep_req),
  .rx_valid   (rx_valid),
  .idle_pulse (idle_pulse),
  .frame_err  (frame_err),
  .asleep     (asleep)
);

// File: tb/test_uart_rx_wake.sv
module test_uart_rx_wake;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OSR        = 16;
  localparam int BITC       = OSR * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       char9 = 1'b0;
  logic       wake_addr = 1'b0;
  logic       idle_after_stop = 1'b0;
  logic       sleep_req = 1'b0;
  logic [8:0] rx_data;
  logic       rx_valid;
  logic       idle_pulse;
  logic       frame_err;
  logic       asleep;

  int n_chk = 0;
  int n_bad = 0;
  int v_cnt = 0;
  int i_cnt = 0;
  int e_cnt = 0;
  logic [8:0] v_data = '0;
  logic       v_ferr = 1'b0;

  uart_rx_wake i_uart_rx_wake (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd), .char9(char9),
    .wake_addr(wake_addr), .idle_after_stop(idle_after_stop),
    .sleep_req(sleep_req), .rx_data(rx_data), .rx_valid(rx_valid),
    .idle_pulse(idle_pulse), .frame_err(frame_err), .asleep(asleep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    forever @(negedge clk) os_tick = ~os_tick;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        v_cnt++;
        v_data = rx_data;
        v_ferr = frame_err;
      end
      if (frame_err) e_cnt++;
      if (idle_pulse) i_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bits(input int n);
    repeat (n * BITC) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input bit nine, input bit stopv, input int gap);
    rxd = 1'b0; bits(1);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd = v[i]; bits(1);
    end
    rxd = stopv; bits(1);
    rxd = 1'b1; bits(gap);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 valid", rx_valid, 0);
    check("R12 ferr", frame_err, 0);
    check("R12 idle", idle_pulse, 0);
    check("R12 asleep", asleep, 0);
    bits(12);
    check("R6 idle after reset", i_cnt, 1);
    bits(12);
    check("R6 no repeat idle", i_cnt, 1);
  endtask

  task automatic t_basic;
    int v0;
    char9 = 0; v0 = v_cnt;
    send(9'h0A5, 0, 1, 2);
    check("R1 count", v_cnt - v0, 1);
    check("R1 data", v_data, 9'h0A5);
    check("R1 ferr", v_ferr, 0);
    send(9'h03C, 0, 1, 2);
    check("R1 data2", v_data, 9'h03C);
  endtask

  task automatic t_nine;
    char9 = 1;
    send(9'h13C, 1, 1, 2);
    check("R2 bit8 set", v_data, 9'h13C);
    send(9'h0C3, 1, 1, 2);
    check("R2 bit8 clear", v_data, 9'h0C3);
    char9 = 0;
  endtask

  task automatic t_frame;
    int v0, e0;
    v0 = v_cnt; e0 = e_cnt;
    send(9'h05A, 0, 0, 3);
    check("R4 count", v_cnt - v0, 1);
    check("R4 ferr", v_ferr, 1);
    check("R4 data", v_data, 9'h05A);
    check("R4 ferr count", e_cnt - e0, 1);
  endtask

  task automatic t_glitch;
    int v0;
    v0 = v_cnt;
    rxd = 1'b0; repeat (4 * TICK_DIV) @(negedge clk);
    rxd = 1'b1; bits(3);
    check("R3 glitch dropped", v_cnt - v0, 0);
    send(9'h081, 0, 1, 2);
    check("R3 next char", v_data, 9'h081);
  endtask

  task automatic t_early(input bit after_stop, input int exp);
    int i0;
    char9 = 0; idle_after_stop = after_stop;
    bits(12);
    i0 = i_cnt;
    send(9'h0FF, 0, 1, 3);
    send(9'h000, 0, 1, 3);
    if (after_stop) check("R8 no idle in gap", i_cnt - i0, exp);
    else            check("R7 early idle", i_cnt - i0, exp);
  endtask

  task automatic t_thresh;
    int i0;
    idle_after_stop = 1; char9 = 0;
    bits(12); i0 = i_cnt;
    send(9'h0AA, 0, 1, 10);
    check("R5 8-bit idle at 10", i_cnt - i0, 1);
    char9 = 1;
    bits(12); i0 = i_cnt;
    send(9'h1AA, 1, 1, 10);
    check("R5 9-bit no idle at 10", i_cnt - i0, 0);
    bits(2);
    check("R5 9-bit idle at 11", i_cnt - i0, 1);
    char9 = 0;
  endtask

  task automatic t_wake_mark;
    int v0, e0;
    wake_addr = 1; char9 = 0;
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    check("R9 asleep", asleep, 1);
    v0 = v_cnt; e0 = e_cnt;
    send(9'h012, 0, 1, 2);
    check("R10 plain ignored", v_cnt - v0, 0);
    send(9'h012, 0, 0, 3);
    check("R9 no ferr asleep", e_cnt - e0, 0);
    check("R10 still asleep", asleep, 1);
    send(9'h085, 0, 1, 2);
    check("R10 mark delivered", v_data, 9'h085);
    check("R10 mark count", v_cnt - v0, 1);
    check("R10 woke", asleep, 0);
    char9 = 1;
    @(negedge clk); sleep_req = 1; @(negedge clk); sleep_req = 0;
    v0 = v_cnt;
    send(9'h0FF, 1, 1, 2);
    check("R10 9-bit bit8 low ignored", v_cnt - v0, 0);
    send(9'h101, 1, 1, 2);
    check("R10 9-bit mark", v_data, 9'h101);
    check("R10 9-bit woke", asleep, 0);
    char9 = 0;
  endtask

  task automatic t_wake_idle;
    int v0, i0;
    wake_addr = 0; idle_after_stop = 1; char9 = 0;
    send(9'h055, 0, 1, 1);
    sleep_req = 1; @(negedge clk); sleep_req = 0;
    check("R9 asleep idle mode", asleep, 1);
    v0 = v_cnt; i0 = i_cnt;
    send(9'h033, 0, 1, 2);
    check("R11 char ignored", v_cnt - v0, 0);
    check("R11 still asleep", asleep, 1);
    bits(12);
    check("R11 idle seen", i_cnt - i0, 1);
    check("R11 woke", asleep, 0);
    check("R11 nothing delivered", v_cnt - v0, 0);
    send(9'h044, 0, 1, 2);
    check("R11 next delivered", v_data, 9'h044);
    check("R11 next count", v_cnt - v0, 1);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_nine;
    t_frame;
    t_glitch;
    t_early(0, 1);
    t_early(1, 0);
    t_thresh;
    t_wake_mark;
    t_wake_idle;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule